// File: doc/BRIEF.md
# Status Message Queue with Message-Waiting Indicator

This block collects short status messages from the sensing logic and presents them one at a time to a host interface. Three event sources feed it: a calibration-begin strobe, a calibration-done strobe and a key-state-change stream that carries a payload. One more message, the power-up notice, is posted by the block itself in the first cycle after reset. Messages wait in an ordered queue. The oldest one is copied into a read-out holding register, and an active-low, open-drain style indicator tells the host that something is waiting.

The host reads the holding register and then pulses `msg_ack`. The indicator is then released, and it stays released for a fixed gap even when more messages are pending. After the gap the next message is loaded and the indicator falls again, so every message produces a fresh falling edge.

Back-pressure rules:
- The output side behaves like a valid/ready pair. `msg_valid` holds the message and its fields stay stable until a cycle in which `msg_ack` is high.
- An `msg_ack` pulse while no message is shown has no effect.
- The input strobes have no ready signal and are always sampled. A message that finds the queue full is discarded, and the loss is reported on the next message delivered.

Top module: `msg_change_queue`

## Requirements
- R1: While `rst_n` is low, `chg_n` is 1, `chg_oe` is 0 and `msg_valid` is 0.
- R2: After reset is released, a message of kind 0 (power-up, payload 0) is posted. It is shown with `chg_n` low from the second rising edge after release, and it stays there until it is acknowledged.
- R3: `chg_n` is low and `chg_oe` is high exactly while a message is shown in the holding register. `chg_n` is high and `chg_oe` is low otherwise.
- R4: When the queue and the holding register are empty and a strobe is sampled at edge k, the message is not yet shown after edge k. It is shown after edge k+1.
- R5: A shown message keeps its kind, payload and flag until `msg_ack` is sampled high. The indicator is released at the next edge. `msg_ack` sampled while nothing is shown is ignored.
- R6: After an acknowledge, the indicator stays released for at least `GAP_CYC` cycles (default 2). When another message is already queued, it is released for exactly `GAP_CYC` cycles.
- R7: Messages are delivered in arrival order. Strobes sampled in the same cycle are queued in this order: power-up notice, calibration-begin, key change, calibration-done.
- R8: Each calibration-begin strobe yields one message of kind 1 and each calibration-done strobe yields one of kind 2, both with payload 0. Each key strobe yields one message of kind 3 that carries `key_payload`.
- R9: The queue holds `DEPTH` messages (default 8) in addition to the one in the holding register. Free space is judged on the occupancy before the edge, and messages that do not fit are dropped, newest first.
- R10: After any drop, `msg_ovf` is 1 on the next message loaded into the holding register at a later edge. It is 0 on later messages until another drop occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cal_begin | input | 1 | One-cycle strobe: calibration has started |
| cal_done | input | 1 | One-cycle strobe: calibration has finished |
| key_valid | input | 1 | One-cycle strobe: key state change |
| key_payload | input | PAY_W | Key change payload, sampled with `key_valid` |
| msg_ack | input | 1 | Host has finished reading the held message |
| msg_valid | output | 1 | Holding register contains a message |
| msg_kind | output | 2 | Kind: 0 power-up, 1 cal begin, 2 cal done, 3 key |
| msg_payload | output | PAY_W | Payload of held message |
| msg_ovf | output | 1 | A message was dropped before this one |
| chg_n | output | 1 | Message-waiting indicator, low = waiting |
| chg_oe | output | 1 | Pull-down enable for an open-drain pad |

## Verification
A strobe that reaches an idle block is sampled at one edge, enters the queue at that edge and appears in the holding register one edge later. The bench therefore samples at the falling edge after each of those two rising edges. After an acknowledge sampled at edge e, the indicator is high after e, and the next queued message appears after edge e+`GAP_CYC`. A monitor counts the high cycles and requires exactly `GAP_CYC` whenever the scoreboard already held a pending item at acknowledge time. All sampling happens on falling edges, so results never depend on process order at the rising edge.

// File: rtl/msg_q_pkg.sv
package msg_q_pkg;
  typedef enum logic [1:0] {
    KIND_POWERUP   = 2'd0,
    KIND_CAL_BEGIN = 2'd1,
    KIND_CAL_DONE  = 2'd2,
    KIND_KEY       = 2'd3
  } msg_kind_e;

  localparam int unsigned KIND_W  = 2;
  localparam int unsigned N_SLOTS = 4;
  localparam int unsigned SLOT_CW = $clog2(N_SLOTS + 1);
endpackage

// File: rtl/msg_q_merge.sv
module msg_q_merge
  import msg_q_pkg::*;
#(
  parameter int unsigned PAY_W = 6,
  localparam int unsigned W    = KIND_W + PAY_W
) (
  input  logic               boot_req,
  input  logic               cal_begin,
  input  logic               key_valid,
  input  logic [PAY_W-1:0]   key_payload,
  input  logic               cal_done,
  output logic [SLOT_CW-1:0] slot_cnt,
  output logic [W-1:0]       slot_data [N_SLOTS]
);
  logic [N_SLOTS-1:0] req;
  logic [W-1:0]       src [N_SLOTS];

  // Source index order is the queueing order within one cycle.
  always_comb begin
    req[0] = boot_req;  src[0] = {KIND_POWERUP,   {PAY_W{1'b0}}};
    req[1] = cal_begin; src[1] = {KIND_CAL_BEGIN, {PAY_W{1'b0}}};
    req[2] = key_valid; src[2] = {KIND_KEY,       key_payload};
    req[3] = cal_done;  src[3] = {KIND_CAL_DONE,  {PAY_W{1'b0}}};
  end

  // Compact the active sources into the low slots.
  always_comb begin
    slot_cnt = '0;
    for (int i = 0; i < N_SLOTS; i++) slot_data[i] = '0;
    for (int i = 0; i < N_SLOTS; i++) begin
      if (req[i]) begin
        slot_data[slot_cnt[$clog2(N_SLOTS)-1:0]] = src[i];
        slot_cnt = slot_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/msg_q_fifo.sv
module msg_q_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned NW    = 4,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned NCW  = $clog2(NW + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCW-1:0] wr_cnt,
  input  logic [W-1:0]   wr_data [NW],
  input  logic           pop,
  output logic [W-1:0]   head,
  output logic           nonempty,
  output logic           drop
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] count_q;
  logic [CW-1:0] acc_w;
  int unsigned   req_i, free_i, acc_i;

  // Space is judged on occupancy before the edge; surplus is dropped.
  always_comb begin
    req_i  = int'(wr_cnt);
    free_i = DEPTH - int'(count_q);
    acc_i  = (req_i < free_i) ? req_i : free_i;
    drop   = (req_i > free_i);
    acc_w  = CW'(acc_i);
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NW; i++) begin
      if (i < int'(acc_w)) mem[wptr_q + AW'(i)] <= wr_data[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      wptr_q  <= wptr_q + AW'(acc_w);
      if (pop) rptr_q <= rptr_q + 1'b1;
      count_q <= count_q + acc_w - CW'(pop);
    end
  end

  assign head     = mem[rptr_q];
  assign nonempty = (count_q != '0);

  p_pop_needs_item_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> count_q != '0);
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));
  p_full_after_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    drop && !pop |=> count_q == CW'(DEPTH));
endmodule

// File: rtl/msg_q_holder.sv
module msg_q_holder #(
  parameter int unsigned W       = 8,
  parameter int unsigned GAP_CYC = 2,
  localparam int unsigned GW     = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         nonempty,
  input  logic [W-1:0] head,
  input  logic         ovf_in,
  input  logic         ack,
  output logic         load,
  output logic         valid,
  output logic [W-1:0] data,
  output logic         ovf_out
);
  typedef enum logic [1:0] {H_IDLE, H_SHOW, H_GAP} hstate_e;
  hstate_e       state_q;
  logic [GW-1:0] gcnt_q;
  logic          gap_end;

  assign gap_end = (gcnt_q == GW'(GAP_CYC - 1));
  assign load    = nonempty && ((state_q == H_IDLE) || (state_q == H_GAP && gap_end));
  assign valid   = (state_q == H_SHOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= H_IDLE;
      gcnt_q  <= '0;
      data    <= '0;
      ovf_out <= 1'b0;
    end else begin
      if (load) begin
        data    <= head;
        ovf_out <= ovf_in;
      end
      case (state_q)
        H_IDLE: if (load) state_q <= H_SHOW;
        H_SHOW: if (ack) begin
          state_q <= H_GAP;
          gcnt_q  <= '0;
        end
        H_GAP: begin
          if (gap_end) state_q <= load ? H_SHOW : H_IDLE;
          else         gcnt_q  <= gcnt_q + 1'b1;
        end
        default: state_q <= H_IDLE;
      endcase
    end
  end

  p_idle_load_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == H_IDLE) && nonempty |=> valid);
  p_release_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid && ack |=> !valid);
  p_hold_until_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ack |=> valid && $stable(data) && $stable(ovf_out));

  generate
    if (GAP_CYC >= 2) begin : g_gap_chk
      p_min_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(valid) |=> !valid);
    end
  endgenerate
endmodule

// File: rtl/msg_change_queue.sv
module msg_change_queue
  import msg_q_pkg::*;
#(
  parameter int unsigned PAY_W   = 6,
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned GAP_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cal_begin,
  input  logic             cal_done,
  input  logic             key_valid,
  input  logic [PAY_W-1:0] key_payload,
  input  logic             msg_ack,
  output logic             msg_valid,
  output logic [1:0]       msg_kind,
  output logic [PAY_W-1:0] msg_payload,
  output logic             msg_ovf,
  output logic             chg_n,
  output logic             chg_oe
);
  localparam int unsigned W = KIND_W + PAY_W;

  logic               boot_q;
  logic [SLOT_CW-1:0] slot_cnt;
  logic [W-1:0]       slot_data [N_SLOTS];
  logic [W-1:0]       head, held;
  logic               nonempty, drop, load, ovf_pend_q;

  // Power-up notice is requested in the first cycle after reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) boot_q <= 1'b1;
    else        boot_q <= 1'b0;
  end

  // Loss flag rides on the next message loaded at a later edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ovf_pend_q <= 1'b0;
    else if (load) ovf_pend_q <= drop;
    else if (drop) ovf_pend_q <= 1'b1;
  end

  msg_q_merge #(.PAY_W(PAY_W)) u_merge (
    .boot_req(boot_q), .cal_begin(cal_begin), .key_valid(key_valid),
    .key_payload(key_payload), .cal_done(cal_done),
    .slot_cnt(slot_cnt), .slot_data(slot_data)
  );

  msg_q_fifo #(.W(W), .DEPTH(DEPTH), .NW(N_SLOTS)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_cnt(slot_cnt), .wr_data(slot_data),
    .pop(load), .head(head), .nonempty(nonempty), .drop(drop)
  );

  msg_q_holder #(.W(W), .GAP_CYC(GAP_CYC)) u_hold (
    .clk(clk), .rst_n(rst_n), .nonempty(nonempty), .head(head),
    .ovf_in(ovf_pend_q), .ack(msg_ack), .load(load),
    .valid(msg_valid), .data(held), .ovf_out(msg_ovf)
  );

  assign msg_kind    = held[W-1 -: KIND_W];
  assign msg_payload = held[PAY_W-1:0];
  assign chg_n       = !msg_valid;
  assign chg_oe      = msg_valid;

  always_comb begin
    if (!rst_n) a_reset_released_r1: assert (chg_n && !chg_oe);
  end

  p_flag_set_by_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    drop && !load |=> ovf_pend_q);
  p_boot_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_q |=> !boot_q);
endmodule

// File: tb/msg_change_queue_test.sv
module msg_change_queue_test;
  import msg_q_pkg::*;
  localparam int unsigned PAY_W = 6;
  localparam int unsigned DEPTH = 8;
  localparam int unsigned GAP   = 2;
  localparam int unsigned W     = KIND_W + PAY_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cal_begin = 0, cal_done = 0, key_valid = 0;
  logic [PAY_W-1:0] key_payload = '0;
  logic mon_ack = 0, extra_ack = 0, msg_ack;
  logic msg_valid, msg_ovf, chg_n, chg_oe;
  logic [1:0] msg_kind;
  logic [PAY_W-1:0] msg_payload;

  int checks = 0, failures = 0;
  logic [W-1:0] sb[$];
  logic exp_ovf = 0;
  logic ack_hold = 0;
  int ph = 0;
  bit finished = 0;

  assign msg_ack = mon_ack | extra_ack;
  always #4 clk = ~clk;

  msg_change_queue #(.PAY_W(PAY_W), .DEPTH(DEPTH), .GAP_CYC(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .cal_begin(cal_begin), .cal_done(cal_done),
    .key_valid(key_valid), .key_payload(key_payload), .msg_ack(msg_ack),
    .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_payload(msg_payload),
    .msg_ovf(msg_ovf), .chg_n(chg_n), .chg_oe(chg_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic push_key(input logic [PAY_W-1:0] p, input bit dropped);
    @(negedge clk);
    key_valid = 1; key_payload = p;
    if (dropped) exp_ovf = 1;
    else sb.push_back({KIND_KEY, p});
    @(negedge clk);
    key_valid = 0;
  endtask

  task automatic push_cal(input bit done);
    @(negedge clk);
    if (done) begin cal_done = 1; sb.push_back({KIND_CAL_DONE, {PAY_W{1'b0}}}); end
    else begin cal_begin = 1; sb.push_back({KIND_CAL_BEGIN, {PAY_W{1'b0}}}); end
    @(negedge clk);
    cal_begin = 0; cal_done = 0;
  endtask

  task automatic wait_drain();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (sb.size() == 0 && !msg_valid && ph == 3) break;
    end
    repeat (3) @(negedge clk);
  endtask

  // Scoreboard monitor and host model
  task automatic compare_head();
    logic [W-1:0] e;
    if (sb.size() == 0) begin
      check(0, "R7 unexpected message", int'({msg_kind, msg_payload}), -1);
      return;
    end
    e = sb.pop_front();
    check({msg_kind, msg_payload} == e, "R7/R8 message content",
          int'({msg_kind, msg_payload}), int'(e));
    check(msg_ovf == exp_ovf, "R10 overflow flag", int'(msg_ovf), int'(exp_ovf));
    check(!chg_n && chg_oe, "R3 indicator asserted with message", int'(chg_n), 0);
    exp_ovf = 0;
  endtask

  initial begin
    int nmsg = 0, wcnt = 0, gap = 0;
    bit exact = 0;
    logic [W+0:0] held;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      case (ph)
        0, 3: begin
          if (msg_valid) begin
            if (ph == 3) begin
              if (exact) check(gap == GAP, "R6 exact release gap", gap, GAP);
              else       check(gap >= GAP, "R6 minimum release gap", gap, GAP);
            end
            compare_head();
            held = {msg_ovf, msg_kind, msg_payload};
            nmsg++; wcnt = nmsg % 3; ph = 1;
          end else if (ph == 3) begin
            gap++;
            check(chg_n && !chg_oe, "R3 indicator released without message", int'(chg_n), 1);
          end
        end
        1: begin
          check(msg_valid && held == {msg_ovf, msg_kind, msg_payload},
                "R5 message held until ack", int'({msg_ovf, msg_kind, msg_payload}), int'(held));
          if (!ack_hold) begin
            if (wcnt == 0) begin mon_ack = 1; ph = 2; end
            else wcnt--;
          end
        end
        2: begin
          mon_ack = 0;
          check(chg_n && !msg_valid, "R5 release after ack", int'(chg_n), 1);
          exact = (sb.size() > 0);
          gap = 1; ph = 3;
        end
        default: ph = 0;
      endcase
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      check(0, "watchdog expired", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(chg_n && !chg_oe && !msg_valid, "R1 outputs during reset", int'(chg_n), 1);
    sb.push_back({KIND_POWERUP, {PAY_W{1'b0}}});
    rst_n = 1;
    @(negedge clk);
    check(chg_n && !msg_valid, "R2 not shown after first edge", int'(chg_n), 1);
    @(negedge clk);
    check(!chg_n && msg_valid, "R2 power-up notice shown after second edge", int'(chg_n), 0);
    wait_drain();

    // R4 latency from idle
    @(negedge clk);
    key_valid = 1; key_payload = 6'h15; sb.push_back({KIND_KEY, 6'h15});
    @(negedge clk);
    key_valid = 0;
    check(!msg_valid && chg_n, "R4 not shown after sampling edge", int'(msg_valid), 0);
    @(negedge clk);
    check(msg_valid && !chg_n, "R4 shown one edge later", int'(msg_valid), 1);
    wait_drain();

    // R8 calibration pair, R7 ordering of sequential pushes
    push_cal(0);
    push_key(6'h2A, 0);
    push_cal(1);
    push_key(6'h01, 0);
    wait_drain();

    // R7 same-cycle order: cal begin, key, cal done
    @(negedge clk);
    cal_begin = 1; key_valid = 1; key_payload = 6'h3C; cal_done = 1;
    sb.push_back({KIND_CAL_BEGIN, {PAY_W{1'b0}}});
    sb.push_back({KIND_KEY, 6'h3C});
    sb.push_back({KIND_CAL_DONE, {PAY_W{1'b0}}});
    @(negedge clk);
    cal_begin = 0; key_valid = 0; cal_done = 0;
    wait_drain();

    // R5 ack while nothing shown is ignored
    @(negedge clk); extra_ack = 1;
    @(negedge clk); extra_ack = 0;
    repeat (2) @(negedge clk);
    check(!msg_valid && chg_n, "R5 idle ack has no effect", int'(msg_valid), 0);
    @(negedge clk);
    key_valid = 1; key_payload = 6'h07; sb.push_back({KIND_KEY, 6'h07});
    @(negedge clk);
    key_valid = 0; extra_ack = 1;
    @(negedge clk);
    extra_ack = 0;
    check(msg_valid, "R5 ack before message shown is ignored", int'(msg_valid), 1);
    wait_drain();

    // R9/R10 fill the queue behind a held message, then overflow
    ack_hold = 1;
    push_key(6'h10, 0);
    repeat (3) @(negedge clk);
    for (int i = 0; i < DEPTH; i++) push_key(PAY_W'(6'h20 + i), 0);
    push_key(6'h30, 1);
    push_key(6'h31, 1);
    repeat (2) @(negedge clk);
    check(msg_valid && msg_payload == 6'h10 && !msg_ovf, "R9 held message kept during overflow",
          int'(msg_payload), 6'h10);
    ack_hold = 0;
    wait_drain();

    // R10 flag cleared: a fresh message after the overflow carries no flag
    push_key(6'h3F, 0);
    wait_drain();

    check(sb.size() == 0, "R7 all messages delivered", sb.size(), 0);
    check(chg_n && !chg_oe, "R3 released when empty", int'(chg_n), 1);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule